// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible face of a small LCD controller. It holds a control word, three panel timing words, a read-only status word and a subpanel word behind a single-cycle 32-bit register interface with word-aligned byte offsets. It drives the live mode fields (palette mode, TFT select, mono select and the display enable) and the panel dimensions to a separate pixel engine, and it raises one level-sensitive interrupt line.

The pixel engine never touches the registers. It reports back through three one-cycle pulses: a frame was finished, the palette was loaded, or a synchronisation error occurred. This unit folds those pulses into status flags. It also applies the flag changes that belong to a toggle of the enable bit. What a disable does to the flags depends on the palette mode. What an enable does depends on whether the controller was idle.

Top module: `lcdc_csr`

## Requirements
- R1: After reset every stored field and flag is zero, the controller is idle, `disp_invalid` is 1, `irq` is 0, `lcd_enable` is 0 and both panel dimensions read as 1. A control read then returns 0xFE000C34 and a timing0 read returns 0x0000000F.
- R2: A write to offset 0x00 takes palette mode from bits 21:20, TFT from bit 7, the interrupt enables from bits 4:3, mono from bit 1 and enable from bit 0, and keeps the other bits under mask 0x01CFF300. A read of 0x00 returns 0xFE000C34 ORed with the kept bits, TFT at bits 23 and 7, palette mode at 21:20, enables at 4:3, mono at 1 and enable at 0.
- R3: A write to 0x04 (0x08) sets the panel width (height) output to bits 9:0 plus one and keeps the whole word. A read of 0x04 returns the kept word with bits 3:0 forced to one. A read of 0x08 returns the kept word unchanged.
- R4: Offset 0x0C keeps the full word and reads it back ORed with 0xFC000000. Offset 0x14 keeps the written word ANDed with 0xA1FFFFFF and reads it back as kept. Both kept words also appear on their output ports.
- R5: A read of 0x10 returns palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. A write to 0x10 changes nothing.
- R6: An access to an offset with nonzero bits 1:0, or above 0x14, pulses `bad_access` in the same cycle. A read of such an offset returns zero, and a write to it changes nothing.
- R7: `irq` is registered and, right after each clock edge, equals (frame-done AND enable bit 0) OR (palette-done AND enable bit 1) OR sync-error, all taken from the state stored at that edge.
- R8: A control write that turns enable from 1 to 0 clears sync-error, sets frame-done unless the palette mode written is 1, and makes the controller idle.
- R9: A control write that turns enable from 0 to 1 clears frame-done and palette-done only when the controller is idle, and always leaves it not idle. A control write that keeps the enable value applies no flag change.
- R10: While enabled, an engine frame pulse sets frame-done, a palette pulse sets palette-done, and a sync-error pulse sets sync-error and clears the enable bit without making the controller idle. Pulses are ignored while disabled, and also in a cycle whose control write toggles enable.
- R11: `disp_invalid` is set by reset and by any write to 0x04 or 0x08. It is cleared by an accepted engine frame pulse, and a dimension write in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when no read |
| bad_access | output | 1 | Access to an unmapped or misaligned offset |
| eng_frame_done | input | 1 | Engine pulse: frame finished |
| eng_pal_done | input | 1 | Engine pulse: palette loaded |
| eng_sync_err | input | 1 | Engine pulse: synchronisation error |
| lcd_enable | output | 1 | Live enable bit |
| pal_mode | output | 2 | Live palette mode |
| tft_sel | output | 1 | Live TFT select |
| mono_sel | output | 1 | Live mono select |
| panel_width | output | DIM_W+1 | Width in pixels |
| panel_height | output | DIM_W+1 | Height in lines |
| timing2_cfg | output | DATA_W | Stored third timing word |
| subpanel_cfg | output | DATA_W | Stored masked subpanel word |
| disp_invalid | output | 1 | Display contents must be redrawn |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted flag register shows up one edge after the disturbance, both on `irq` (when its enable is set, or always for sync-error) and in the next status read. A wrong idle state stays hidden until the next enable. The bench therefore follows every engine error with a re-enable and a status read. A wrong stored mask or field position shows up only on readback or on the mode outputs, so every random write is followed by outputs compared in the same step, and random reads cover all offsets, including misaligned and unmapped ones.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

   localparam logic [31:0] CTL_KEEP_MASK = 32'h01CF_F300;
   localparam logic [31:0] CTL_RD_FORCE  = 32'hFE00_0C34;
   localparam logic [31:0] T0_RD_FORCE   = 32'h0000_000F;
   localparam logic [31:0] T2_RD_FORCE   = 32'hFC00_0000;
   localparam logic [31:0] SUB_WR_MASK   = 32'hA1FF_FFFF;

   // word index of each register (byte offset / 4)
   localparam int unsigned WIDX_CTL  = 0;
   localparam int unsigned WIDX_T0   = 1;
   localparam int unsigned WIDX_T1   = 2;
   localparam int unsigned WIDX_T2   = 3;
   localparam int unsigned WIDX_STAT = 4;
   localparam int unsigned WIDX_SUB  = 5;

   typedef enum logic [2:0] {
      SEL_CTL,
      SEL_T0,
      SEL_T1,
      SEL_T2,
      SEL_STAT,
      SEL_SUB,
      SEL_NONE
   } reg_sel_e;

   typedef struct packed {
      logic       frame;
      logic       pal;
      logic       sync;
   } eng_evt_t;

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
   import lcdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              acc,
   output reg_sel_e          sel,
   output logic              bad
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   assign widx = addr[ADDR_W-1:2];

   always_comb begin
      if (addr[1:0] != 2'b00)                 sel = SEL_NONE;
      else if (widx == IDX_W'(WIDX_CTL))      sel = SEL_CTL;
      else if (widx == IDX_W'(WIDX_T0))       sel = SEL_T0;
      else if (widx == IDX_W'(WIDX_T1))       sel = SEL_T1;
      else if (widx == IDX_W'(WIDX_T2))       sel = SEL_T2;
      else if (widx == IDX_W'(WIDX_STAT))     sel = SEL_STAT;
      else if (widx == IDX_W'(WIDX_SUB))      sel = SEL_SUB;
      else                                    sel = SEL_NONE;
   end

   assign bad = acc && (sel == SEL_NONE);
endmodule

// File: rtl/lcdc_dim_reg.sv
module lcdc_dim_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DIM_W  = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       word_q,
   output logic [DIM_W:0]          count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (we) word_q <= wdata;
   end

   assign count = {1'b0, word_q[DIM_W-1:0]} + {{DIM_W{1'b0}}, 1'b1};
endmodule

// File: rtl/lcdc_flag_ctl.sv
module lcdc_flag_ctl
   import lcdc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic       wr_en_bit,
   input  logic [1:0] wr_plm,
   input  logic [1:0] ien_next,
   input  logic       dim_we,
   input  eng_evt_t   evt,
   output logic       en_q,
   output logic       fd_q,
   output logic       pd_q,
   output logic       sd_q,
   output logic       idle_q,
   output logic       inv_q,
   output logic       irq_q
);
   logic toggle, accept;
   logic en_d, fd_d, pd_d, sd_d, idle_d, inv_d;

   assign toggle = ctl_we && (wr_en_bit != en_q);
   assign accept = en_q && !toggle;

   always_comb begin
      en_d   = en_q;
      fd_d   = fd_q;
      pd_d   = pd_q;
      sd_d   = sd_q;
      idle_d = idle_q;
      inv_d  = inv_q;
      if (toggle) begin
         en_d = wr_en_bit;
         if (!wr_en_bit) begin
            sd_d   = 1'b0;
            idle_d = 1'b1;
            if (wr_plm != 2'd1) fd_d = 1'b1;
         end else begin
            if (idle_q) begin
               fd_d = 1'b0;
               pd_d = 1'b0;
            end
            idle_d = 1'b0;
         end
      end else if (accept) begin
         if (evt.frame) begin
            fd_d  = 1'b1;
            inv_d = 1'b0;
         end
         if (evt.pal) pd_d = 1'b1;
         if (evt.sync) begin
            sd_d = 1'b1;
            en_d = 1'b0;
         end
      end
      if (dim_we) inv_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         fd_q   <= 1'b0;
         pd_q   <= 1'b0;
         sd_q   <= 1'b0;
         idle_q <= 1'b1;
         inv_q  <= 1'b1;
         irq_q  <= 1'b0;
      end else begin
         en_q   <= en_d;
         fd_q   <= fd_d;
         pd_q   <= pd_d;
         sd_q   <= sd_d;
         idle_q <= idle_d;
         inv_q  <= inv_d;
         irq_q  <= (fd_d & ien_next[0]) | (pd_d & ien_next[1]) | sd_d;
      end
   end
endmodule

// File: rtl/lcdc_csr.sv
module lcdc_csr
   import lcdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DIM_W  = 10,
   parameter int unsigned N_DIM  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bad_access,
   input  logic              eng_frame_done,
   input  logic              eng_pal_done,
   input  logic              eng_sync_err,
   output logic              lcd_enable,
   output logic [1:0]        pal_mode,
   output logic              tft_sel,
   output logic              mono_sel,
   output logic [DIM_W:0]    panel_width,
   output logic [DIM_W:0]    panel_height,
   output logic [DATA_W-1:0] timing2_cfg,
   output logic [DATA_W-1:0] subpanel_cfg,
   output logic              disp_invalid,
   output logic              irq
);
   initial begin
      assert (DATA_W == 32) else $error("lcdc_csr: DATA_W must be 32");
      assert (ADDR_W >= 5)  else $error("lcdc_csr: ADDR_W too small for map");
      assert (DIM_W >= 4 && DIM_W <= 16) else $error("lcdc_csr: DIM_W out of range");
      assert (N_DIM == 2)   else $error("lcdc_csr: two dimension words expected");
   end

   reg_sel_e          sel;
   logic              ctl_we, t2_we, sub_we, dim_we;
   logic [1:0]        plm_q, ien_q, ien_next;
   logic              tft_q, mono_q;
   logic [DATA_W-1:0] keep_q, t2_q, sub_q;
   logic              en_q, fd_q, pd_q, sd_q, idle_q, inv_q, irq_q;
   logic [DATA_W-1:0] dim_word [N_DIM];
   logic [DIM_W:0]    dim_cnt  [N_DIM];
   logic [N_DIM-1:0]  dim_we_v;
   eng_evt_t          evt;

   lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .acc  (bus_wr | bus_rd),
      .sel  (sel),
      .bad  (bad_access)
   );

   assign ctl_we = bus_wr && (sel == SEL_CTL);
   assign t2_we  = bus_wr && (sel == SEL_T2);
   assign sub_we = bus_wr && (sel == SEL_SUB);

   // width word then height word
   for (genvar g = 0; g < N_DIM; g++) begin : g_dim
      localparam reg_sel_e MY_SEL = (g == 0) ? SEL_T0 : SEL_T1;
      assign dim_we_v[g] = bus_wr && (sel == MY_SEL);
      lcdc_dim_reg #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_dim (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (dim_we_v[g]),
         .wdata  (bus_wdata),
         .word_q (dim_word[g]),
         .count  (dim_cnt[g])
      );
   end
   assign dim_we = |dim_we_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plm_q  <= '0;
         ien_q  <= '0;
         tft_q  <= 1'b0;
         mono_q <= 1'b0;
         keep_q <= '0;
      end else if (ctl_we) begin
         plm_q  <= bus_wdata[21:20];
         ien_q  <= bus_wdata[4:3];
         tft_q  <= bus_wdata[7];
         mono_q <= bus_wdata[1];
         keep_q <= bus_wdata & CTL_KEEP_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t2_q  <= '0;
         sub_q <= '0;
      end else begin
         if (t2_we)  t2_q  <= bus_wdata;
         if (sub_we) sub_q <= bus_wdata & SUB_WR_MASK;
      end
   end

   assign ien_next  = ctl_we ? bus_wdata[4:3] : ien_q;
   assign evt.frame = eng_frame_done;
   assign evt.pal   = eng_pal_done;
   assign evt.sync  = eng_sync_err;

   lcdc_flag_ctl u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .wr_en_bit (bus_wdata[0]),
      .wr_plm    (bus_wdata[21:20]),
      .ien_next  (ien_next),
      .dim_we    (dim_we),
      .evt       (evt),
      .en_q      (en_q),
      .fd_q      (fd_q),
      .pd_q      (pd_q),
      .sd_q      (sd_q),
      .idle_q    (idle_q),
      .inv_q     (inv_q),
      .irq_q     (irq_q)
   );

   logic [DATA_W-1:0] ctl_rd, stat_rd;
   assign ctl_rd  = CTL_RD_FORCE | keep_q |
                    {8'h00, tft_q, 1'b0, plm_q, 12'h000, tft_q, 2'b00, ien_q, 1'b0, mono_q, en_q};
   assign stat_rd = {25'd0, pd_q, 3'b000, sd_q, 1'b0, fd_q};

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_CTL:  bus_rdata = ctl_rd;
            SEL_T0:   bus_rdata = dim_word[0] | T0_RD_FORCE;
            SEL_T1:   bus_rdata = dim_word[1];
            SEL_T2:   bus_rdata = t2_q | T2_RD_FORCE;
            SEL_STAT: bus_rdata = stat_rd;
            SEL_SUB:  bus_rdata = sub_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign lcd_enable   = en_q;
   assign pal_mode     = plm_q;
   assign tft_sel      = tft_q;
   assign mono_sel     = mono_q;
   assign panel_width  = dim_cnt[0];
   assign panel_height = dim_cnt[1];
   assign timing2_cfg  = t2_q;
   assign subpanel_cfg = sub_q;
   assign disp_invalid = inv_q;
   assign irq          = irq_q;
endmodule

// File: rtl/lcdc_csr_chk.sv
module lcdc_csr_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bad_access,
   input logic              eng_frame_done,
   input logic              eng_pal_done,
   input logic              eng_sync_err,
   input logic              lcd_enable,
   input logic              disp_invalid,
   input logic              irq,
   input logic              fd_q,
   input logic              pd_q,
   input logic              sd_q
);
   logic at_ctl, at_stat, at_dim, any_evt;
   assign at_ctl  = (bus_addr == ADDR_W'(8'h00));
   assign at_stat = (bus_addr == ADDR_W'(8'h10));
   assign at_dim  = (bus_addr == ADDR_W'(8'h04)) || (bus_addr == ADDR_W'(8'h08));
   assign any_evt = eng_frame_done | eng_pal_done | eng_sync_err;

   // R2
   ctl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_ctl) |-> ((bus_rdata & 32'hFE00_0C34) == 32'hFE00_0C34));

   // R5
   stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_stat && !any_evt) |=> ($stable(fd_q) && $stable(pd_q) && $stable(sd_q)));

   // R6
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_access && bus_rd) |-> (bus_rdata == '0));

   // R7
   sync_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sd_q |-> irq);

   // R8
   disable_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_ctl && lcd_enable && !bus_wdata[0] && bus_wdata[21:20] != 2'd1)
      |=> (fd_q && !sd_q));

   // R10
   sync_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_q) |-> !lcd_enable);

   // R11
   dim_write_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_dim) |=> disp_invalid);
endmodule

bind lcdc_csr lcdc_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_wr         (bus_wr),
   .bus_rd         (bus_rd),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .bad_access     (bad_access),
   .eng_frame_done (eng_frame_done),
   .eng_pal_done   (eng_pal_done),
   .eng_sync_err   (eng_sync_err),
   .lcd_enable     (lcd_enable),
   .disp_invalid   (disp_invalid),
   .irq            (irq),
   .fd_q           (fd_q),
   .pd_q           (pd_q),
   .sd_q           (sd_q)
);

// File: tb/test_lcdc_csr.sv
`timescale 1ns/1ps
module test_lcdc_csr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bad_access;
   logic        eng_frame_done = 1'b0, eng_pal_done = 1'b0, eng_sync_err = 1'b0;
   logic        lcd_enable, tft_sel, mono_sel, disp_invalid, irq;
   logic [1:0]  pal_mode;
   logic [10:0] panel_width, panel_height;
   logic [31:0] timing2_cfg, subpanel_cfg;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   lcdc_csr i_lcdc_csr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bad_access(bad_access), .eng_frame_done(eng_frame_done),
      .eng_pal_done(eng_pal_done), .eng_sync_err(eng_sync_err),
      .lcd_enable(lcd_enable), .pal_mode(pal_mode), .tft_sel(tft_sel),
      .mono_sel(mono_sel), .panel_width(panel_width), .panel_height(panel_height),
      .timing2_cfg(timing2_cfg), .subpanel_cfg(subpanel_cfg),
      .disp_invalid(disp_invalid), .irq(irq)
   );

   // reference model state
   logic [1:0]  m_plm, m_ien;
   logic        m_tft, m_mono, m_en, m_fd, m_pd, m_sd, m_idle, m_inv;
   logic [31:0] m_keep, m_t0, m_t1, m_t2, m_sub;

   task automatic model_reset();
      m_plm = 0; m_ien = 0; m_tft = 0; m_mono = 0; m_en = 0;
      m_fd = 0; m_pd = 0; m_sd = 0; m_idle = 1; m_inv = 1;
      m_keep = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0;
   endtask

   function automatic bit is_bad(input logic [7:0] a);
      return (a[1:0] != 2'b00) || (a > 8'h14);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      if (is_bad(a)) return 32'h0;
      case (a)
         8'h00: return 32'hFE000C34 | m_keep | (32'(m_tft) << 23) | (32'(m_plm) << 20)
                       | (32'(m_tft) << 7) | (32'(m_ien) << 3) | (32'(m_mono) << 1) | 32'(m_en);
         8'h04: return m_t0 | 32'hF;
         8'h08: return m_t1;
         8'h0C: return m_t2 | 32'hFC000000;
         8'h10: return (32'(m_pd) << 6) | (32'(m_sd) << 2) | 32'(m_fd);
         default: return m_sub;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (is_bad(a)) return "R6";
      case (a)
         8'h00: return "R2";
         8'h04, 8'h08: return "R3";
         8'h10: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                             input logic ef, input logic ep, input logic es);
      logic tog, acc, dimw;
      tog  = w && (a == 8'h00) && (d[0] != m_en);
      acc  = m_en && !tog;
      dimw = w && (a == 8'h04 || a == 8'h08);
      if (w && !is_bad(a)) begin
         case (a)
            8'h00: begin
               m_plm = d[21:20]; m_tft = d[7]; m_ien = d[4:3]; m_mono = d[1];
               m_keep = d & 32'h01CFF300;
               if (tog) begin
                  if (!d[0]) begin
                     m_sd = 0; m_idle = 1;
                     if (d[21:20] != 2'd1) m_fd = 1;
                  end else begin
                     if (m_idle) begin m_fd = 0; m_pd = 0; end
                     m_idle = 0;
                  end
                  m_en = d[0];
               end
            end
            8'h04: m_t0 = d;
            8'h08: m_t1 = d;
            8'h0C: m_t2 = d;
            8'h14: m_sub = d & 32'hA1FFFFFF;
            default: ;
         endcase
      end
      if (acc) begin
         if (ef) begin m_fd = 1; m_inv = 0; end
         if (ep) m_pd = 1;
         if (es) begin m_sd = 1; m_en = 0; end
      end
      if (dimw) m_inv = 1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_outputs();
      chk("R7 irq", 32'(irq), 32'((m_fd & m_ien[0]) | (m_pd & m_ien[1]) | m_sd));
      chk("R9 lcd_enable", 32'(lcd_enable), 32'(m_en));
      chk("R11 disp_invalid", 32'(disp_invalid), 32'(m_inv));
      chk("R2 modes", {27'd0, pal_mode, tft_sel, mono_sel, 1'b0},
          {27'd0, m_plm, m_tft, m_mono, 1'b0});
      chk("R3 dims", {5'd0, panel_height, 5'd0, panel_width},
          {5'd0, 11'(m_t1[9:0]) + 11'd1, 5'd0, 11'(m_t0[9:0]) + 11'd1});
      chk("R4 t2 port", timing2_cfg, m_t2);
      chk("R4 sub port", subpanel_cfg, m_sub);
   endtask

   task automatic step(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                       input logic ef, input logic ep, input logic es);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      eng_frame_done = ef; eng_pal_done = ep; eng_sync_err = es;
      #1;
      if (w || r) chk("R6 bad_access", 32'(bad_access), 32'(is_bad(a)));
      if (r) chk(tag_of(a), bus_rdata, exp_read(a));
      @(posedge clk);
      model_step(w, a, d, ef, ep, es);
      #1;
      bus_wr = 0; bus_rd = 0; eng_frame_done = 0; eng_pal_done = 0; eng_sync_err = 0;
      chk_outputs();
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(1, 0, a, d, 0, 0, 0);
   endtask
   task automatic rd(input logic [7:0] a);
      step(0, 1, a, 32'h0, 0, 0, 0);
   endtask
   task automatic eng(input logic ef, input logic ep, input logic es);
      step(0, 0, 8'h00, 32'h0, ef, ep, es);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0011));
      model_reset();
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 invalid", 32'(disp_invalid), 32'h1);
      chk("R1 enable", 32'(lcd_enable), 32'h0);
      chk("R1 width", 32'(panel_width), 32'h1);
      rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C); rd(8'h10); rd(8'h14);

      // R3 dimensions and masks
      wr(8'h04, 32'hABCD_E27F); rd(8'h04);
      wr(8'h08, 32'h1234_53FF); rd(8'h08);
      // R4
      wr(8'h0C, 32'h0123_4567); rd(8'h0C);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
      // R2 all-ones control write keeps enable low via bit 0 = 0
      wr(8'h00, 32'hFFFF_FFFE); rd(8'h00);
      wr(8'h00, 32'h0000_0000);
      // R5 status write ignored
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
      // R6 misaligned and unmapped
      rd(8'h02); rd(8'h18); wr(8'h41, 32'hFFFF_FFFF); rd(8'h00);

      // R9 enable from idle clears flags, R10 pulses set them
      wr(8'h00, 32'h0000_0019); rd(8'h10);
      eng(0, 1, 0); rd(8'h10);
      eng(1, 0, 0); rd(8'h10);
      // R8 disable with palette mode 1: frame-done not forced; re-enable first
      wr(8'h00, 32'h0010_0018);
      wr(8'h00, 32'h0010_0019); rd(8'h10);
      wr(8'h00, 32'h0010_0018); rd(8'h10);
      // R10 pulses ignored while disabled
      eng(1, 1, 1); rd(8'h10);
      // R10 sync error while enabled, ien off: irq anyway, enable dropped
      wr(8'h00, 32'h0000_0001);
      eng(0, 1, 1); rd(8'h10); rd(8'h00);
      // R9 re-enable not from idle keeps flags
      wr(8'h00, 32'h0000_0001); rd(8'h10);
      // R9 same enable value: no flag change
      wr(8'h00, 32'h0000_0019); rd(8'h10);
      // R8 disable clears sync error, sets frame-done
      wr(8'h00, 32'h0000_0018); rd(8'h10);
      // R10 collision: toggling write drops engine pulses
      wr(8'h00, 32'h0000_0019);
      step(1, 0, 8'h00, 32'h0000_0018, 0, 1, 1); rd(8'h10);
      // R11 dimension write in the same cycle as an accepted frame pulse
      wr(8'h00, 32'h0000_0019);
      step(1, 0, 8'h04, 32'h0000_0010, 1, 0, 0); rd(8'h10);
      eng(1, 0, 0);

      // random phase
      for (int i = 0; i < 600; i++) begin
         int unsigned k;
         logic [7:0]  a;
         logic [31:0] d;
         k = $urandom_range(0, 7);
         case (k)
            0, 1, 2, 3, 4, 5: a = 8'(k * 4);
            6: a = 8'h10;
            default: a = 8'($urandom);
         endcase
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d[21:20] = 2'd1;
         step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, d,
              $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
              $urandom_range(0, 11) == 0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule